// File: doc/BRIEF.md
# Real-Time Counter and Watchdog with Shared Prescaler

This block holds an 8-bit real-time counter and a watchdog timer that share one programmable power-of-two divider. A 6-bit mode register sets three things: the counter's clock source (the instruction-cycle enable or transitions on an external pin), which pin edge counts, and whether the divider sits in front of the counter or behind the watchdog's raw tick. The same 3-bit divide code gives a different ratio on each side. On the counter side it selects 2 to 256. On the watchdog side it selects 1 to 128.

Software writes the mode register and reads it back. It also reads and writes the counter, and it issues a watchdog clear strobe when it services the watchdog. The watchdog counts divided ticks in a WDT_W-bit register. It reports a time-out as a single-cycle pulse when that register wraps. The external pin input is expected to be synchronized already, and the raw watchdog tick comes from an oscillator outside the block.

Top module: `rtc_wdt_timer`

## Requirements
- R1: After a synchronous reset with rst_n low, mode_rd reads 6'h3F: external pin source, falling edge, divider on the watchdog, code 7. cnt_rd reads 8'hFF and wdt_timeout is 0.
- R2: A mode_we cycle stores mode_wdata, and mode_rd shows it from the next cycle. The new setting governs counting from that next cycle on. Field positions are: bit 5 selects the source (1 = pin), bit 4 selects the edge (1 = high-to-low), bit 3 assigns the divider (1 = watchdog), and bits 2..0 hold the divide code.
- R3: With bit 5 = 0 and bit 3 = 1, the counter advances by one in each cycle with icyc_en high and holds when icyc_en is low.
- R4: With bit 5 = 1, the counter ignores icyc_en. A pin change counts when it differs from the value sampled on the previous clock: low-to-high when bit 4 = 0, high-to-low when bit 4 = 1. A level held for many cycles counts once. The previous value after reset is taken as low.
- R5: With bit 3 = 0, the counter advances once per 2^(code+1) source events.
- R6: With bit 3 = 1, the watchdog register advances once per 2^code wdt_tick cycles. With bit 3 = 0 it advances on every wdt_tick.
- R7: The counter wraps from 8'hFF to 8'h00. A cnt_we cycle loads cnt_wdata and takes priority over any increment in that cycle. When bit 3 = 0, it also zeroes the divider count.
- R8: wdt_clr zeroes the watchdog register and takes priority over a tick in the same cycle. When bit 3 = 1, it also zeroes the divider count.
- R9: wdt_timeout goes high for exactly one cycle, in the cycle after an advance takes the watchdog register from all ones to zero.
- R10: The divider count is free-running modulo 256 on its input events. It passes an event when (count + 1) is a multiple of the ratio, so a code change takes effect against the running count without restarting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 6 | Mode register write data |
| mode_rd | output | 6 | Mode register contents |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter write data |
| cnt_rd | output | 8 | Counter value |
| ext_pin | input | 1 | Synchronized external count input |
| icyc_en | input | 1 | Instruction-cycle enable |
| wdt_tick | input | 1 | Raw watchdog tick, one cycle per tick |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wdt_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
A wrong divider count or a misdecoded ratio shows on cnt_rd as a missed or early increment, at the first divided event after the fault: at most 256 source events later. Behind the watchdog the same fault only moves the time-out pulse, so it can stay hidden for up to 2^WDT_W divided ticks. The directed watchdog runs therefore count the exact cycle of the pulse. A wrong edge register shows as a double or missing count on the first held pin level. Every cycle, the bench compares all three outputs with a model, so a divergence is reported in the cycle it reaches a port.

// File: rtl/rtc_wdt_pkg.sv
// Shared types for the counter/watchdog block: the mode register layout.
package rtc_wdt_pkg;
    localparam int MODE_W = 6;
    localparam int CODE_W = 3;

    // Mode register fields, MSB first; bit positions are software-visible.
    typedef struct packed {
        logic              ext_src;   // 1: count pin transitions
        logic              fall_edge; // 1: count high-to-low
        logic              to_wdt;    // 1: divider sits behind the watchdog
        logic [CODE_W-1:0] code;      // divide code
    } tmr_mode_t;

    localparam tmr_mode_t MODE_RST = '{ext_src: 1'b1, fall_edge: 1'b1,
                                       to_wdt: 1'b1, code: '1};
endpackage

// File: rtl/tmr_src_sel.sv
// Counter source selection. Picks the instruction-cycle enable or a qualifying
// edge of the external pin. Assumes ext_pin is already synchronized to clk.
// The edge is found by comparing the pin with its value on the previous clock,
// so a held level yields exactly one event.
module tmr_src_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic icyc_en,
    input  logic ext_src,
    input  logic fall_edge,
    output logic src_evt
);
    logic pin_prev_q;
    logic rise;
    logic fall;

    // Remember the pin value of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev_q <= 1'b0;
        else        pin_prev_q <= ext_pin;
    end

    // Decode transitions and choose the event source.
    always_comb begin
        rise    = ext_pin & ~pin_prev_q;
        fall    = ~ext_pin & pin_prev_q;
        src_evt = ext_src ? (fall_edge ? fall : rise) : icyc_en;
    end

    // A counted pin event always follows a change of the sampled pin (R4).
    assert_pin_evt_is_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_src && src_evt) |-> (ext_pin != pin_prev_q));
endmodule

// File: rtl/tmr_prescaler.sv
// Shared power-of-two divider. The count is free-running modulo 2^PSC_W on
// evt_in. An input event passes when the low exp_sel bits of the count are all
// ones, giving a ratio of 2^exp_sel. exp_sel is at most PSC_W.
module tmr_prescaler #(
    parameter int PSC_W = 8,
    localparam int EXP_W = $clog2(PSC_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             clr,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             evt_out
);
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] bit_ok;

    // Per-bit terminal test: bits below the exponent must be ones.
    for (genvar i = 0; i < PSC_W; i++) begin : g_term
        assign bit_ok[i] = (EXP_W'(i) < exp_sel) ? psc_q[i] : 1'b1;
    end

    // Pass an event on the terminal count.
    assign evt_out = evt_in & (&bit_ok);

    // Running divider count with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      psc_q <= '0;
        else if (clr)    psc_q <= '0;
        else if (evt_in) psc_q <= psc_q + PSC_W'(1);
    end

    // A clear leaves a zero count in the next cycle (R10).
    assert_clr_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (psc_q == '0));
    // Without an input event the count holds (R10).
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !evt_in) |=> $stable(psc_q));
endmodule

// File: rtl/tmr_wdt.sv
// Watchdog register. Counts advance strobes in WDT_W bits and emits a
// registered one-cycle time-out when the register wraps. The clear strobe
// wins over an advance in the same cycle. Assumes WDT_W >= 2.
module tmr_wdt #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    output logic timeout
);
    logic [WDT_W-1:0] wdt_q;
    logic             to_q;

    // Count advances and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_q <= '0;
            to_q  <= 1'b0;
        end else if (clr) begin
            wdt_q <= '0;
            to_q  <= 1'b0;
        end else begin
            to_q <= adv & (&wdt_q);
            if (adv) wdt_q <= wdt_q + WDT_W'(1);
        end
    end

    assign timeout = to_q;

    // The time-out pulse lasts a single cycle (R9).
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        to_q |=> !to_q);
    // A clear resets the register and suppresses the pulse (R8).
    assert_clr_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wdt_q == '0 && !to_q));
endmodule

// File: rtl/rtc_wdt_timer.sv
// Top level: the mode register, the 8-bit counter, and the routing of the
// shared divider to either the counter or the watchdog. The counter side uses
// ratio 2^(code+1), the watchdog side 2^code. Assumes PSC_W >= 2^CODE_W and
// single-cycle strobes on wdt_tick.
module rtc_wdt_timer
    import rtc_wdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PSC_W = 8,
    parameter int WDT_W = 8,
    localparam int EXP_W = $clog2(PSC_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode_rd,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_rd,
    input  logic              ext_pin,
    input  logic              icyc_en,
    input  logic              wdt_tick,
    input  logic              wdt_clr,
    output logic              wdt_timeout
);
    tmr_mode_t        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic             src_evt;
    logic             psc_in;
    logic             psc_out;
    logic             psc_clr;
    logic [EXP_W-1:0] exp_sel;
    logic             cnt_inc;
    logic             wdt_adv;

    // Mode register: software write, fixed reset pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= MODE_RST;
        else if (mode_we) mode_q <= tmr_mode_t'(mode_wdata);
    end

    tmr_src_sel u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .icyc_en   (icyc_en),
        .ext_src   (mode_q.ext_src),
        .fall_edge (mode_q.fall_edge),
        .src_evt   (src_evt)
    );

    // Route the divider and derive its exponent for the assigned side.
    always_comb begin
        exp_sel = mode_q.to_wdt ? EXP_W'(mode_q.code)
                                : EXP_W'(mode_q.code) + EXP_W'(1);
        psc_in  = mode_q.to_wdt ? wdt_tick : src_evt;
        psc_clr = mode_q.to_wdt ? wdt_clr : cnt_we;
        cnt_inc = mode_q.to_wdt ? src_evt : psc_out;
        wdt_adv = mode_q.to_wdt ? psc_out : wdt_tick;
    end

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_in  (psc_in),
        .clr     (psc_clr),
        .exp_sel (exp_sel),
        .evt_out (psc_out)
    );

    // Counter: software load wins, otherwise wrap-around increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '1;
        else if (cnt_we)  cnt_q <= cnt_wdata;
        else if (cnt_inc) cnt_q <= cnt_q + CNT_W'(1);
    end

    tmr_wdt #(.WDT_W(WDT_W)) u_wdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (wdt_adv),
        .clr     (wdt_clr),
        .timeout (wdt_timeout)
    );

    assign mode_rd = mode_q;
    assign cnt_rd  = cnt_q;

    // A mode write is visible on the next cycle (R2).
    assert_mode_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_rd == $past(mode_wdata)));
    // A counter write is visible on the next cycle (R7).
    assert_cnt_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (cnt_rd == $past(cnt_wdata)));
    // With no event and no write the counter holds (R3).
    assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !cnt_inc) |=> $stable(cnt_rd));
    // With the pin as source, icyc_en alone never moves the counter (R4).
    assert_pin_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.ext_src && !cnt_we && !src_evt) |=> $stable(cnt_rd));
endmodule

// File: tb/sim_rtc_wdt_timer.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random stimulus. Every cycle the
// outputs are compared against a behavioural model built from the requirements.
module sim_rtc_wdt_timer;
    localparam int WDT_W = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_we = 1'b0;
    logic [5:0] mode_wdata = '0;
    logic [5:0] mode_rd;
    logic       cnt_we = 1'b0;
    logic [7:0] cnt_wdata = '0;
    logic [7:0] cnt_rd;
    logic       ext_pin = 1'b0;
    logic       icyc_en = 1'b0;
    logic       wdt_tick = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       wdt_timeout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [5:0] m_mode;
    logic [7:0] m_cnt;
    int         m_psc;
    int         m_wdt;
    logic       m_prev;
    logic       m_to;

    always #4 clk = ~clk;

    rtc_wdt_timer #(.WDT_W(WDT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_we(mode_we), .mode_wdata(mode_wdata),
        .mode_rd(mode_rd), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rd(cnt_rd),
        .ext_pin(ext_pin), .icyc_en(icyc_en), .wdt_tick(wdt_tick),
        .wdt_clr(wdt_clr), .wdt_timeout(wdt_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string cnt_tag(input logic [5:0] md);
        if (!md[3])     return "R5";
        else if (md[5]) return "R4";
        else            return "R3";
    endfunction

    task automatic model_reset();
        m_mode = 6'h3F; m_cnt = 8'hFF; m_psc = 0; m_wdt = 0;
        m_prev = 1'b0;  m_to = 1'b0;
    endtask

    // Advance the model by one clock using the inputs currently driven.
    task automatic model_step();
        bit rise, fall, src, asg, pev, pout, cinc, winc;
        int r;
        rise = !m_prev && ext_pin;
        fall = m_prev && !ext_pin;
        src  = m_mode[5] ? (m_mode[4] ? fall : rise) : icyc_en;
        asg  = m_mode[3];
        r    = asg ? (1 << m_mode[2:0]) : (2 << m_mode[2:0]);
        pev  = asg ? wdt_tick : src;
        pout = pev && ((m_psc % r) == r - 1);
        cinc = asg ? src : pout;
        winc = asg ? pout : wdt_tick;
        if ((cnt_we && !asg) || (wdt_clr && asg)) m_psc = 0;
        else if (pev) m_psc = (m_psc + 1) % 256;
        if (cnt_we) m_cnt = cnt_wdata;
        else if (cinc) m_cnt = m_cnt + 8'd1;
        if (wdt_clr) begin
            m_wdt = 0; m_to = 1'b0;
        end else begin
            m_to = winc && (m_wdt == (1 << WDT_W) - 1);
            if (winc) m_wdt = (m_wdt + 1) % (1 << WDT_W);
        end
        if (mode_we) m_mode = mode_wdata;
        m_prev = ext_pin;
    endtask

    // One clock: step the model, let the edge pass, compare at the negedge.
    task automatic run1();
        logic [5:0] md;
        md = m_mode;
        if (!rst_n) model_reset(); else model_step();
        @(posedge clk);
        @(negedge clk);
        chk("R2 mode", mode_rd, m_mode);
        chk(cnt_tag(md), cnt_rd, m_cnt);
        chk("R9 timeout", wdt_timeout, m_to);
        mode_we = 1'b0; cnt_we = 1'b0; wdt_clr = 1'b0;
    endtask

    task automatic set_mode(input logic [5:0] v);
        mode_we = 1'b1; mode_wdata = v; run1();
    endtask

    task automatic write_cnt(input logic [7:0] v);
        cnt_we = 1'b1; cnt_wdata = v; run1();
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        @(negedge clk);
        run1(); run1(); run1();
        rst_n = 1'b1;
        // R1: reset values
        chk("R1 mode", mode_rd, 6'h3F);
        chk("R1 cnt", cnt_rd, 8'hFF);
        chk("R1 timeout", wdt_timeout, 0);

        // R3: internal source, divider on watchdog
        set_mode(6'h08);
        chk("R2 readback", mode_rd, 6'h08);
        write_cnt(8'hFE);
        icyc_en = 1'b1; run1(); run1();
        chk("R7 wrap", cnt_rd, 8'h00);
        icyc_en = 1'b0; run1(); run1(); run1();
        chk("R3 hold", cnt_rd, 8'h00);
        icyc_en = 1'b1; cnt_we = 1'b1; cnt_wdata = 8'h40; run1();
        chk("R7 load priority", cnt_rd, 8'h40);

        // R4: pin rising, icyc_en ignored
        icyc_en = 1'b0;
        set_mode(6'h28);
        write_cnt(8'h10);
        icyc_en = 1'b1;
        ext_pin = 1'b1; repeat (4) run1();
        ext_pin = 1'b0; repeat (2) run1();
        chk("R4 rising once", cnt_rd, 8'h11);
        set_mode(6'h38);
        ext_pin = 1'b1; repeat (2) run1();
        chk("R4 falling no count on rise", cnt_rd, 8'h11);
        ext_pin = 1'b0; repeat (2) run1();
        chk("R4 falling", cnt_rd, 8'h12);

        // R5: divider on counter, code 1 => 1:4
        icyc_en = 1'b0;
        set_mode(6'h01);
        write_cnt(8'h00);
        icyc_en = 1'b1; repeat (8) run1();
        chk("R5 ratio 4", cnt_rd, 8'h02);
        icyc_en = 1'b0;

        // R6/R9: divider on watchdog, code 2 => 1:4
        set_mode(6'h0A);
        wdt_clr = 1'b1; run1();
        wdt_tick = 1'b1;
        repeat (1023) run1();
        chk("R6 no early timeout", wdt_timeout, 0);
        run1();
        chk("R9 timeout pulse", wdt_timeout, 1);
        wdt_tick = 1'b0; run1();
        chk("R9 pulse ends", wdt_timeout, 0);

        // R8: clear wins over tick, 1:1
        set_mode(6'h08);
        wdt_clr = 1'b1; run1();
        wdt_tick = 1'b1; repeat (200) run1();
        wdt_clr = 1'b1; run1();
        repeat (255) run1();
        chk("R8 restart no timeout", wdt_timeout, 0);
        run1();
        chk("R8 timeout after full count", wdt_timeout, 1);
        wdt_tick = 1'b0;

        // R10 and mixed: seeded random stimulus
        for (int i = 0; i < 6000; i++) begin
            mode_we    = ($urandom % 40) == 0;
            mode_wdata = 6'($urandom);
            cnt_we     = ($urandom % 60) == 0;
            cnt_wdata  = 8'($urandom);
            ext_pin    = (($urandom % 3) == 0) ? ~ext_pin : ext_pin;
            icyc_en    = ($urandom % 4) != 0;
            wdt_tick   = ($urandom % 2) == 0;
            wdt_clr    = ($urandom % 300) == 0;
            run1();
        end

        // R1: reset after activity
        mode_we = 1'b0; cnt_we = 1'b0; wdt_clr = 1'b0; wdt_tick = 1'b0;
        rst_n = 1'b0; run1(); rst_n = 1'b1;
        chk("R1 mode after rerun", mode_rd, 6'h3F);
        chk("R1 cnt after rerun", cnt_rd, 8'hFF);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule